// File: doc/BRIEF.md
# Bus Ownership Exchange Controller

This block lives in the external bus interface of a processor. It follows the processor's machine cycles clock by clock and decides when the address, data and control outputs are handed to another bus master and when they are taken back. A memory, I/O or opcode-fetch machine cycle runs through the states T1, T2, optional wait states and T3. An internal cycle, during which the external bus is idle, lasts a single clock. The other master asks for the bus by pulling an active-low request. The controller waits for the end of the current machine cycle, floats the bus outputs for one clock and only then pulls an active-low acknowledge.

The same block screens the hardware reset pin. A low level counts as a reset only after it has been seen for a minimum number of consecutive clocks. While that reset holds, the bus is floated and any exchange is cancelled. When the pin returns high, the processor restarts with an opcode fetch from address zero.

The core tells the block the kind of the next machine cycle on `mc_kind`. It asks for wait states on `wait_req`.

Top module: `bus_exchange_ctrl`

## Requirements
- R1: After a reset ends (pin sampled high while `t_phase` is 0), the next clock starts an external cycle in T1. `addr_out` is 0 through that cycle's T1, T2 and T3. From the following machine cycle on, `addr_out` follows `core_addr`.
- R2: At the clock that ends a machine cycle, `mc_kind` picks the next one: 0 is internal, 1 is opcode fetch, 2 is memory and 3 is I/O. Kinds 1 to 3 run T1, then T2, then T3. Kind 0 lasts one clock in TI. `t_phase` codes are reset 0, TI 1, T1 2, T2 3, TW 4, T3 5 and bus-away 6. `mc_end` is high in TI and T3.
- R3: `wait_req` sampled high in T2 or TW leads to TW on the next clock. When it is sampled low there, the next clock is T3. It has no effect in T1.
- R4: If `bus_req_n` is low at the clock that ends a machine cycle, the next clock shows `t_phase` 6 with `bus_oe` 0 and `bus_ack_n` still 1.
- R5: One clock after the bus is floated, `bus_ack_n` goes to 0 while `bus_oe` stays 0. It stays there as long as `bus_req_n` stays low.
- R6: A request that is low during T1, T2 or TW releases nothing before the cycle's last clock. `bus_oe` stays 1 and `bus_ack_n` stays 1 until then.
- R7: When `bus_req_n` is sampled high during the grant, `bus_ack_n` returns to 1 on the next clock while `bus_oe` is still 0. On the clock after that, a new machine cycle starts with `bus_oe` 1.
- R8: `reset_pin_n` sampled low on 6 consecutive clocks puts the block in reset (`t_phase` 0) from the sixth of those clocks. In reset `bus_oe` is 0 and `bus_ack_n` is 1, and this lasts until the pin is sampled high.
- R9: A low pulse on `reset_pin_n` that lasts fewer than 6 clocks leaves the cycle sequence unchanged. The low-clock count starts again from zero whenever the pin is high.
- R10: A qualified reset overrides the exchange. It drops an active grant (`bus_ack_n` back to 1) and ignores requests for as long as it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous power-on reset of the flops, active low |
| reset_pin_n | input | 1 | Hardware reset pin, active low, qualified by duration |
| bus_req_n | input | 1 | Bus request from the other master, active low |
| mc_kind | input | 2 | Kind of the next machine cycle: 0 internal, 1 fetch, 2 memory, 3 I/O |
| wait_req | input | 1 | Wait-state request, sampled in T2 and TW |
| core_addr | input | ADDR_W | Address from the core |
| bus_ack_n | output | 1 | Bus acknowledge, active low |
| bus_oe | output | 1 | 1 drives address, data and control outputs; 0 floats them |
| addr_out | output | ADDR_W | Address toward the pads, forced to 0 during the restart fetch |
| t_phase | output | 3 | Current clock state of the machine cycle |
| mc_end | output | 1 | High on the last clock of a machine cycle |
| restart_fetch | output | 1 | High from reset until the end of the restart fetch cycle |

## Verification
The request is tried on a fetch cycle stretched by two wait states, where it arrives mid-cycle. This separates boundary-only release from early release. It is also tried against a one-clock internal cycle, which shows that release can happen after a single clock. Reset is driven with a five-clock low pulse and then a six-clock low pulse, which separates the qualification threshold from an off-by-one. One six-clock reset is applied while the bus is granted, to show that reset takes priority over the exchange. The restart sequence is checked on both the address value and the cycle states.

// File: rtl/bx_pkg.sv
package bx_pkg;

    typedef enum logic [2:0] {
        PH_RST  = 3'd0,
        PH_TI   = 3'd1,
        PH_T1   = 3'd2,
        PH_T2   = 3'd3,
        PH_TW   = 3'd4,
        PH_T3   = 3'd5,
        PH_AWAY = 3'd6
    } phase_e;

    typedef enum logic [1:0] {
        OWN_HELD    = 2'd0,
        OWN_FLOAT   = 2'd1,
        OWN_GRANTED = 2'd2,
        OWN_RECLAIM = 2'd3
    } owner_e;

    localparam logic [1:0] KIND_INTERNAL = 2'd0;

endpackage

// File: rtl/bx_reset_qualifier.sv
module bx_reset_qualifier #(
    parameter int MIN_LOW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic rst_now
);
    localparam int CW = (MIN_LOW > 2) ? $clog2(MIN_LOW) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW - 1);

    typedef struct packed {
        logic [CW-1:0] lows;
    } qual_t;

    qual_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (pin_n) begin
            nxt_d.lows = '0;
        end else if (cur_q.lows != LIMIT) begin
            nxt_d.lows = cur_q.lows + 1'b1;
        end
    end

    // Low on this clock after MIN_LOW-1 earlier low clocks: the sixth low edge.
    assign rst_now = !pin_n && (cur_q.lows == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/bx_cycle_tracker.sv
module bx_cycle_tracker
    import bx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rst_now,
    input  logic   pin_n,
    input  logic   ext_next,
    input  logic   wait_req,
    input  logic   release_go,
    input  logic   resume,
    output phase_e phase,
    output logic   mc_end,
    output logic   restart
);
    typedef struct packed {
        phase_e ph;
        logic   restart;
    } trk_t;

    trk_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (rst_now) begin
            nxt_d.ph      = PH_RST;
            nxt_d.restart = 1'b1;
        end else begin
            unique case (cur_q.ph)
                PH_RST: begin
                    if (pin_n) nxt_d.ph = PH_T1;
                end
                PH_TI, PH_T3: begin
                    nxt_d.restart = 1'b0;
                    if (release_go)    nxt_d.ph = PH_AWAY;
                    else if (ext_next) nxt_d.ph = PH_T1;
                    else               nxt_d.ph = PH_TI;
                end
                PH_T1: nxt_d.ph = PH_T2;
                PH_T2, PH_TW: begin
                    nxt_d.ph = wait_req ? PH_TW : PH_T3;
                end
                PH_AWAY: begin
                    if (resume) nxt_d.ph = ext_next ? PH_T1 : PH_TI;
                end
                default: nxt_d.ph = PH_RST;
            endcase
        end
    end

    assign phase   = cur_q.ph;
    assign mc_end  = (cur_q.ph == PH_TI) || (cur_q.ph == PH_T3);
    assign restart = cur_q.restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.ph      <= PH_RST;
            cur_q.restart <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/bx_owner_arbiter.sv
module bx_owner_arbiter
    import bx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_now,
    input  logic mc_end,
    input  logic req_n,
    output logic release_go,
    output logic resume,
    output logic floating,
    output logic ack_n
);
    typedef struct packed {
        owner_e st;
    } arb_t;

    arb_t cur_q, nxt_d;

    assign release_go = !rst_now && (cur_q.st == OWN_HELD) && mc_end && !req_n;

    always_comb begin
        nxt_d = cur_q;
        if (rst_now) begin
            nxt_d.st = OWN_HELD;
        end else begin
            unique case (cur_q.st)
                OWN_HELD:    if (release_go) nxt_d.st = OWN_FLOAT;
                OWN_FLOAT:   nxt_d.st = OWN_GRANTED;
                OWN_GRANTED: if (req_n) nxt_d.st = OWN_RECLAIM;
                OWN_RECLAIM: nxt_d.st = OWN_HELD;
                default:     nxt_d.st = OWN_HELD;
            endcase
        end
    end

    assign resume   = (cur_q.st == OWN_RECLAIM);
    assign floating = (cur_q.st != OWN_HELD);
    assign ack_n    = (cur_q.st != OWN_GRANTED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.st <= OWN_HELD;
        else        cur_q    <= nxt_d;
    end
endmodule

// File: rtl/bus_exchange_ctrl.sv
module bus_exchange_ctrl
    import bx_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int MIN_LOW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_pin_n,
    input  logic              bus_req_n,
    input  logic [1:0]        mc_kind,
    input  logic              wait_req,
    input  logic [ADDR_W-1:0] core_addr,
    output logic              bus_ack_n,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] addr_out,
    output logic [2:0]        t_phase,
    output logic              mc_end,
    output logic              restart_fetch
);
    logic   rst_now;
    logic   release_go;
    logic   resume;
    logic   floating;
    logic   restart;
    phase_e phase;

    bx_reset_qualifier #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (reset_pin_n),
        .rst_now (rst_now)
    );

    bx_cycle_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_now    (rst_now),
        .pin_n      (reset_pin_n),
        .ext_next   (mc_kind != KIND_INTERNAL),
        .wait_req   (wait_req),
        .release_go (release_go),
        .resume     (resume),
        .phase      (phase),
        .mc_end     (mc_end),
        .restart    (restart)
    );

    bx_owner_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_now    (rst_now),
        .mc_end     (mc_end),
        .req_n      (bus_req_n),
        .release_go (release_go),
        .resume     (resume),
        .floating   (floating),
        .ack_n      (bus_ack_n)
    );

    assign bus_oe        = (phase != PH_RST) && !floating;
    assign addr_out      = restart ? '0 : core_addr;
    assign t_phase       = phase;
    assign restart_fetch = restart;
endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reset_pin_n,
    input logic              wait_req,
    input logic              bus_ack_n,
    input logic              bus_oe,
    input logic [ADDR_W-1:0] addr_out,
    input logic [2:0]        t_phase,
    input logic              mc_end
);
    assert_ack_floated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack_n |-> !bus_oe);

    assert_float_before_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_n) |-> !$past(bus_oe));

    assert_release_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> ($past(mc_end) || t_phase == 3'd0));

    assert_no_wait_to_t3_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (t_phase == 3'd3 && !wait_req && reset_pin_n) |=> (t_phase == 3'd5));

    assert_restart_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (t_phase == 3'd0 && reset_pin_n) |=> (t_phase == 3'd2 && addr_out == '0));

    assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_phase == 3'd0) |-> (bus_ack_n && !bus_oe));

    assert_reclaim_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_ack_n) && t_phase == 3'd6 && reset_pin_n) |=> bus_oe);
endmodule

bind bus_exchange_ctrl bx_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_pin_n (reset_pin_n),
    .wait_req    (wait_req),
    .bus_ack_n   (bus_ack_n),
    .bus_oe      (bus_oe),
    .addr_out    (addr_out),
    .t_phase     (t_phase),
    .mc_end      (mc_end)
);

// File: tb/test_bus_exchange_ctrl.sv
`timescale 1ns/1ps
module test_bus_exchange_ctrl;
    localparam int AW = 20;
    localparam logic [AW-1:0] CADDR = 20'hABCDE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reset_pin_n = 1'b1;
    logic          bus_req_n = 1'b1;
    logic [1:0]    mc_kind = 2'd0;
    logic          wait_req = 1'b0;
    logic [AW-1:0] core_addr = CADDR;
    logic          bus_ack_n, bus_oe, mc_end, restart_fetch;
    logic [AW-1:0] addr_out;
    logic [2:0]    t_phase;

    always #2.5 clk = ~clk;

    bus_exchange_ctrl #(.ADDR_W(AW), .MIN_LOW(6)) i_bus_exchange_ctrl (
        .clk(clk), .rst_n(rst_n), .reset_pin_n(reset_pin_n), .bus_req_n(bus_req_n),
        .mc_kind(mc_kind), .wait_req(wait_req), .core_addr(core_addr),
        .bus_ack_n(bus_ack_n), .bus_oe(bus_oe), .addr_out(addr_out),
        .t_phase(t_phase), .mc_end(mc_end), .restart_fetch(restart_fetch)
    );

    typedef struct {
        int            at;
        logic [2:0]    ph;
        logic          ack_n;
        logic          oe;
        logic [AW-1:0] addr;
        string         tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Driver: set inputs for the next edge and queue what that edge must produce.
    task automatic step(input logic pin, input logic req, input logic [1:0] kind,
                        input logic wt, input logic [2:0] ph, input logic ack,
                        input logic oe, input logic [AW-1:0] addr, input string tag);
        item_t it;
        reset_pin_n = pin;
        bus_req_n   = req;
        mc_kind     = kind;
        wait_req    = wt;
        it.at = cyc + 1; it.ph = ph; it.ack_n = ack; it.oe = oe; it.addr = addr; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop expected items as the design produces them.
    always @(posedge clk) begin
        cyc++;
        #1;
        while (q.size() > 0 && q[0].at == cyc) begin
            item_t it;
            it = q.pop_front();
            cmp(it.tag, "t_phase",   int'(t_phase),   int'(it.ph));
            cmp(it.tag, "bus_ack_n", int'(bus_ack_n), int'(it.ack_n));
            cmp(it.tag, "bus_oe",    int'(bus_oe),    int'(it.oe));
            cmp(it.tag, "addr_out",  int'(addr_out),  int'(it.addr));
        end
    end

    initial begin
        @(negedge clk);
        step(1, 1, 0, 0, 0, 1, 0, 0, "R8 power-on reset state");
        step(1, 1, 0, 0, 0, 1, 0, 0, "R8 power-on reset state");
        rst_n = 1'b1;
        // Restart fetch from address zero
        step(1, 1, 0, 0, 2, 1, 1, 0,     "R1 restart T1 at zero");
        step(1, 1, 0, 0, 3, 1, 1, 0,     "R1 restart T2 at zero");
        step(1, 1, 1, 0, 5, 1, 1, 0,     "R1 restart T3 at zero");
        step(1, 1, 1, 1, 2, 1, 1, CADDR, "R2 fetch T1, core address passes");
        // Wait states with a request arriving mid-cycle
        step(1, 1, 1, 1, 3, 1, 1, CADDR, "R3 wait ignored in T1");
        step(1, 0, 1, 1, 4, 1, 1, CADDR, "R3 wait inserts TW");
        step(1, 0, 1, 1, 4, 1, 1, CADDR, "R6 no early grant in TW");
        step(1, 0, 0, 0, 5, 1, 1, CADDR, "R6 still driving in T3");
        step(1, 0, 0, 0, 6, 1, 0, CADDR, "R4 float after boundary");
        step(1, 0, 0, 0, 6, 0, 0, CADDR, "R5 acknowledge after float");
        step(1, 0, 0, 0, 6, 0, 0, CADDR, "R5 grant held");
        step(1, 1, 0, 0, 6, 1, 0, CADDR, "R7 ack returns, still floating");
        step(1, 1, 0, 0, 1, 1, 1, CADDR, "R7 new internal cycle driven");
        // Release after a one-clock internal cycle
        step(1, 0, 0, 0, 6, 1, 0, CADDR, "R4 release after internal cycle");
        step(1, 0, 0, 0, 6, 0, 0, CADDR, "R5 grant after internal cycle");
        step(1, 1, 0, 0, 6, 1, 0, CADDR, "R7 ack returns");
        step(1, 1, 2, 0, 2, 1, 1, CADDR, "R7 memory cycle T1");
        // Five-clock reset pulse is ignored
        step(0, 1, 2, 0, 3, 1, 1, CADDR, "R9 short low, T2");
        step(0, 1, 0, 0, 5, 1, 1, CADDR, "R9 short low, T3");
        step(0, 1, 0, 0, 1, 1, 1, CADDR, "R2 internal cycle one clock");
        step(0, 1, 0, 0, 1, 1, 1, CADDR, "R9 short low, TI");
        step(0, 1, 0, 0, 1, 1, 1, CADDR, "R9 fifth low clock ignored");
        step(1, 1, 0, 0, 1, 1, 1, CADDR, "R9 pin high clears count");
        // Six-clock reset with a request pending
        step(0, 1, 0, 0, 1, 1, 1, CADDR, "R9 count restarted");
        step(0, 1, 0, 0, 1, 1, 1, CADDR, "R8 low 2");
        step(0, 1, 0, 0, 1, 1, 1, CADDR, "R8 low 3");
        step(0, 1, 0, 0, 1, 1, 1, CADDR, "R8 low 4");
        step(0, 1, 0, 0, 1, 1, 1, CADDR, "R8 not before sixth low");
        step(0, 0, 0, 0, 0, 1, 0, 0,     "R8 sixth low enters reset");
        step(0, 0, 0, 0, 0, 1, 0, 0,     "R10 request ignored in reset");
        step(1, 1, 0, 0, 2, 1, 1, 0,     "R1 restart after qualified reset");
        step(1, 1, 0, 0, 3, 1, 1, 0,     "R1 restart T2");
        step(1, 0, 0, 0, 5, 1, 1, 0,     "R1 restart T3");
        step(1, 0, 0, 0, 6, 1, 0, CADDR, "R4 float after restart fetch");
        step(1, 0, 0, 0, 6, 0, 0, CADDR, "R5 granted");
        // Reset while granted
        step(0, 0, 0, 0, 6, 0, 0, CADDR, "R10 grant kept, low 1");
        step(0, 0, 0, 0, 6, 0, 0, CADDR, "R10 grant kept, low 2");
        step(0, 0, 0, 0, 6, 0, 0, CADDR, "R10 grant kept, low 3");
        step(0, 0, 0, 0, 6, 0, 0, CADDR, "R10 grant kept, low 4");
        step(0, 0, 0, 0, 6, 0, 0, CADDR, "R10 grant kept, low 5");
        step(0, 0, 0, 0, 0, 1, 0, 0,     "R10 reset drops grant");
        step(1, 1, 0, 0, 2, 1, 1, 0,     "R1 restart T1");
        step(1, 1, 0, 0, 3, 1, 1, 0,     "R1 restart T2");
        step(1, 1, 3, 0, 5, 1, 1, 0,     "R1 restart T3");
        step(1, 1, 3, 0, 2, 1, 1, CADDR, "R2 I/O cycle T1");
        step(1, 1, 0, 0, 3, 1, 1, CADDR, "R2 I/O cycle T2");
        step(1, 1, 0, 0, 5, 1, 1, CADDR, "R2 I/O cycle T3");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 pending expectations: actual=%0d expected=0", q.size());
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule